// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Controller

This block manages a direct-mapped second-level cache between a pipelined host bus and main memory. It holds the tag, valid and dirty state for each line on chip. It looks up every host burst and decides whether the burst hits or misses. On a hit it drives the strobes of an external data SRAM: chip select, output enable, write enable and burst advance. It also paces the host's per-beat ready signal to suit the SRAM style that is in use. A line is 32 bytes, which is four 64-bit beats.

The policy is write-back. A write hit only marks the line dirty. A read miss first evicts a dirty victim through the memory port and then refills the line. A write miss is passed to memory without allocating a line. An I/O master that reaches main memory presents a snoop lookup, and the controller filters it against the tags:
- A dirty hit is flushed to memory before the I/O master is released.
- A write that hits a clean line invalidates that line.

The capacity setting adds one index bit. The default parameters keep the tag array small. A full-size array is obtained by raising `IDX_W`.

Top module: `secCacheTop`

## Requirements
- R1: After reset, every line is invalid. `hostRdy`, `memReq`, `snpAck` and `snpWbReq` are low and `sramStandby` is high. The first read of any address is a miss.
- R2: With `burstSram`=1, a hit of either direction returns four `hostRdy` beats in a 3-1-1-1 pattern. The request clock counts as clock 1. `sramAdv` is high on every hit beat except the last.
- R3: With `burstSram`=0, a read hit returns beats in a 3-2-2-2 pattern and a write hit in a 4-2-2-2 pattern.
- R4: A read miss to a clean or invalid line makes one memory burst with `memWr`=0 at the 32-byte-aligned address. The burst is four `memAck` beats, and each beat is also a `hostRdy` beat. Afterwards the line hits.
- R5: A write hit causes no memory traffic and marks the line dirty. A write miss makes one four-beat burst with `memWr`=1 at the line address and allocates nothing.
- R6: A read miss whose victim line is dirty first writes the victim back (`memWr`=1, at the victim's line address) and then fills the new line.
- R7: With `bigSize`=0 the set index is address bits [IDX_W+4:5]. With `bigSize`=1, bit IDX_W+5 is added above it. As a result, two lines that differ only in that bit evict each other in the small size and both stay resident in the large size.
- R8: `snpReq` is held until `snpAck`. A snoop miss, or a clean read hit, acknowledges with no memory traffic. A clean write hit invalidates the line. A dirty hit raises `snpWbReq` while a four-beat write-back of the line runs, and `snpAck` follows its last beat. The line is then left clean after a snoop read, or invalid after a snoop write.
- R9: With `cacheEn`=0 nothing hits and nothing is allocated: every read fills from memory and every write goes to memory.
- R10: `sramStandby` is high only while the controller is idle, and never together with `sramCs`.
- R11: On a read hit `sramOe` is high and `sramWe` is low on every beat. On a write hit `sramWe` is high and `sramOe` is low on every beat. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cacheEn | input | 1 | Caching enable |
| bigSize | input | 1 | Selects the larger capacity (one more index bit) |
| burstSram | input | 1 | 1: burst SRAM timing, 0: standard SRAM timing |
| hostReq | input | 1 | One-cycle host burst request |
| hostWr | input | 1 | Host burst direction, 1 = write |
| hostAddr | input | ADDR_W | Host burst address |
| hostRdy | output | 1 | Per-beat ready to the host |
| sramCs | output | 1 | Data SRAM chip select |
| sramOe | output | 1 | Data SRAM output enable |
| sramWe | output | 1 | Data SRAM write enable |
| sramAdv | output | 1 | Data SRAM burst advance |
| sramStandby | output | 1 | Low-power standby for the data SRAM |
| memReq | output | 1 | Memory burst request, held until the fourth ack |
| memWr | output | 1 | Memory burst direction, 1 = write |
| memAddr | output | ADDR_W | Memory burst line address |
| memAck | input | 1 | Memory beat acknowledge |
| snpReq | input | 1 | Snoop lookup request, held until acknowledged |
| snpWr | input | 1 | Snoop is for an I/O-master write |
| snpAddr | input | ADDR_W | Snoop address |
| snpAck | output | 1 | Snoop complete |
| snpWbReq | output | 1 | Dirty snooped line is being written back |

## Verification
The assertions assume the following about the block's inputs:
- `burstSram`, `bigSize` and `cacheEn` do not change while a burst or a snoop is in progress.
- `snpReq` stays high until `snpAck` is seen.
- `memAck` arrives only while `memReq` is high.

The stimulus keeps within these limits:
- It changes the configuration only between operations, after a reset where the capacity changes.
- It drops a snoop request on the clock after its acknowledge.
- Its memory model acknowledges every second cycle of a pending request.

// File: rtl/secCachePkg.sv
package secCachePkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOOK, ST_HIT, ST_WB, ST_FILL, ST_WMEM, ST_SLOOK
  } ctlState_t;

  typedef struct packed {
    logic latchHost;
    logic latchSnoop;
    logic tagWrite;
    logic setDirty;
    logic clrDirty;
    logic invalidate;
  } tagCmd_t;

endpackage

// File: rtl/secCacheTags.sv
module secCacheTags
  import secCachePkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6,
  parameter int OFF_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  tagCmd_t           cmd,
  input  logic              cacheEn,
  input  logic              bigSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              lookHit,
  output logic              lookDirty,
  output logic [ADDR_W-1:0] victimAddr,
  output logic [ADDR_W-1:0] lineAddr
);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int SETS  = 2 ** (IDX_W + 1);

  logic [ADDR_W-1:0] curAddr;
  logic [TAG_W-1:0]  tagMem [SETS];
  logic [SETS-1:0]   validV, dirtyV;
  logic [IDX_W:0]    setIdx;
  logic [TAG_W-1:0]  curTag;

  // the extra index bit is also the low tag bit, so stored tags stay valid
  assign setIdx = {bigSize & curAddr[OFF_W+IDX_W], curAddr[OFF_W+IDX_W-1:OFF_W]};
  assign curTag = curAddr[ADDR_W-1:OFF_W+IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr <= '0;
      validV  <= '0;
      dirtyV  <= '0;
    end else begin
      if (cmd.latchHost)       curAddr <= hostAddr;
      else if (cmd.latchSnoop) curAddr <= snpAddr;
      if (cmd.tagWrite) begin
        validV[setIdx] <= 1'b1;
        dirtyV[setIdx] <= 1'b0;
      end
      if (cmd.setDirty) dirtyV[setIdx] <= 1'b1;
      if (cmd.clrDirty) dirtyV[setIdx] <= 1'b0;
      if (cmd.invalidate) begin
        validV[setIdx] <= 1'b0;
        dirtyV[setIdx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.tagWrite) tagMem[setIdx] <= curTag;
  end

  assign lookHit    = cacheEn && validV[setIdx] && (tagMem[setIdx] == curTag);
  assign lookDirty  = validV[setIdx] && dirtyV[setIdx];
  assign victimAddr = {tagMem[setIdx], curAddr[OFF_W+IDX_W-1:OFF_W], {OFF_W{1'b0}}};
  assign lineAddr   = {curAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  // R4
  fill_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd.tagWrite && cacheEn) |=> (lookHit || !cacheEn));

endmodule

// File: rtl/secCacheCtl.sv
module secCacheCtl
  import secCachePkg::*;
#(
  parameter int BEATS = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cacheEn,
  input  logic    burstSram,
  input  logic    hostReq,
  input  logic    hostWr,
  input  logic    snpReq,
  input  logic    snpWr,
  input  logic    lookHit,
  input  logic    lookDirty,
  input  logic    memAck,
  output tagCmd_t cmd,
  output logic    selVictim,
  output logic    hostRdy,
  output logic    memReq,
  output logic    memWr,
  output logic    sramCs,
  output logic    sramOe,
  output logic    sramWe,
  output logic    sramAdv,
  output logic    sramStandby,
  output logic    snpAck,
  output logic    snpWbReq
);
  localparam int BEAT_W = $clog2(BEATS);

  ctlState_t   state;
  logic [BEAT_W-1:0] beat;
  logic [1:0]  waitCnt;
  logic        wrReg, snpWrReg, fromSnoop;
  logic        lastBeat, hitRdy, fillSram, snpDone;

  assign lastBeat = (beat == BEAT_W'(BEATS - 1));
  assign hitRdy   = (state == ST_HIT) && (waitCnt == 2'd0);
  assign fillSram = (state == ST_FILL) && cacheEn;
  assign snpDone  = (state == ST_WB) && fromSnoop && memAck && lastBeat;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beat      <= '0;
      waitCnt   <= '0;
      wrReg     <= 1'b0;
      snpWrReg  <= 1'b0;
      fromSnoop <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hostReq) begin
            wrReg <= hostWr;
            state <= ST_LOOK;
          end else if (snpReq) begin
            snpWrReg <= snpWr;
            state    <= ST_SLOOK;
          end
        end
        ST_LOOK: begin
          beat <= '0;
          if (lookHit) begin
            waitCnt <= (wrReg && !burstSram) ? 2'd2 : 2'd1;
            state   <= ST_HIT;
          end else if (wrReg) begin
            state <= ST_WMEM;
          end else if (lookDirty && cacheEn) begin
            fromSnoop <= 1'b0;
            state     <= ST_WB;
          end else begin
            state <= ST_FILL;
          end
        end
        ST_HIT: begin
          if (waitCnt != 2'd0) begin
            waitCnt <= waitCnt - 2'd1;
          end else begin
            waitCnt <= burstSram ? 2'd0 : 2'd1;
            beat    <= beat + 1'b1;
            if (lastBeat) state <= ST_IDLE;
          end
        end
        ST_WB: begin
          if (memAck) begin
            beat <= beat + 1'b1;
            if (lastBeat) state <= fromSnoop ? ST_IDLE : ST_FILL;
          end
        end
        ST_FILL, ST_WMEM: begin
          if (memAck) begin
            beat <= beat + 1'b1;
            if (lastBeat) state <= ST_IDLE;
          end
        end
        ST_SLOOK: begin
          beat <= '0;
          if (lookHit && lookDirty) begin
            fromSnoop <= 1'b1;
            state     <= ST_WB;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd            = '0;
    cmd.latchHost  = (state == ST_IDLE) && hostReq;
    cmd.latchSnoop = (state == ST_IDLE) && !hostReq && snpReq;
    cmd.setDirty   = (state == ST_LOOK) && lookHit && wrReg;
    cmd.tagWrite   = fillSram && memAck && lastBeat;
    cmd.invalidate = ((state == ST_SLOOK) && lookHit && !lookDirty && snpWrReg) ||
                     (snpDone && snpWrReg);
    cmd.clrDirty   = snpDone && !snpWrReg;
  end

  assign selVictim   = (state == ST_WB);
  assign memReq      = (state == ST_WB) || (state == ST_FILL) || (state == ST_WMEM);
  assign memWr       = (state == ST_WB) || (state == ST_WMEM);
  assign hostRdy     = hitRdy || (memAck && ((state == ST_FILL) || (state == ST_WMEM)));
  assign sramCs      = (state == ST_HIT) || (state == ST_WB) || fillSram;
  assign sramOe      = ((state == ST_HIT) && !wrReg) || (state == ST_WB);
  assign sramWe      = (hitRdy && wrReg) || (fillSram && memAck);
  assign sramAdv     = burstSram && hitRdy && !lastBeat;
  assign sramStandby = (state == ST_IDLE);
  assign snpWbReq    = (state == ST_WB) && fromSnoop;
  assign snpAck      = ((state == ST_SLOOK) && !(lookHit && lookDirty)) || snpDone;

  // R2
  burst_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (hitRdy && burstSram && !lastBeat) |=> hostRdy);

  // R3
  std_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (hitRdy && !burstSram && !lastBeat) |=> !hostRdy);

  // R11
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sramOe && sramWe));

  // R10
  standby_cs_chk: assert property (@(posedge clk) disable iff (rst)
    sramStandby |-> !sramCs);

endmodule

// File: rtl/secCacheTop.sv
module secCacheTop
  import secCachePkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cacheEn,
  input  logic              bigSize,
  input  logic              burstSram,
  input  logic              hostReq,
  input  logic              hostWr,
  input  logic [ADDR_W-1:0] hostAddr,
  output logic              hostRdy,
  output logic              sramCs,
  output logic              sramOe,
  output logic              sramWe,
  output logic              sramAdv,
  output logic              sramStandby,
  output logic              memReq,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic              snpReq,
  input  logic              snpWr,
  input  logic [ADDR_W-1:0] snpAddr,
  output logic              snpAck,
  output logic              snpWbReq
);
  localparam int OFF_W = 5;
  localparam int BEATS = 4;

  tagCmd_t           cmd;
  logic              lookHit, lookDirty, selVictim;
  logic [ADDR_W-1:0] victimAddr, lineAddr;

  secCacheTags #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) uTags (
    .clk(clk), .rst(rst), .cmd(cmd), .cacheEn(cacheEn), .bigSize(bigSize),
    .hostAddr(hostAddr), .snpAddr(snpAddr), .lookHit(lookHit),
    .lookDirty(lookDirty), .victimAddr(victimAddr), .lineAddr(lineAddr)
  );

  secCacheCtl #(.BEATS(BEATS)) uCtl (
    .clk(clk), .rst(rst), .cacheEn(cacheEn), .burstSram(burstSram),
    .hostReq(hostReq), .hostWr(hostWr), .snpReq(snpReq), .snpWr(snpWr),
    .lookHit(lookHit), .lookDirty(lookDirty), .memAck(memAck), .cmd(cmd),
    .selVictim(selVictim), .hostRdy(hostRdy), .memReq(memReq), .memWr(memWr),
    .sramCs(sramCs), .sramOe(sramOe), .sramWe(sramWe), .sramAdv(sramAdv),
    .sramStandby(sramStandby), .snpAck(snpAck), .snpWbReq(snpWbReq)
  );

  assign memAddr = selVictim ? victimAddr : lineAddr;

  // R8
  snp_wb_mem_chk: assert property (@(posedge clk) disable iff (rst)
    snpWbReq |-> (memReq && memWr));

endmodule

// File: tb/sim_secCacheTop.sv
module sim_secCacheTop;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 6;
  localparam logic [ADDR_W-1:0] CONF = ADDR_W'(1) << (5 + IDX_W);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, cacheEn, bigSize, burstSram, hostReq, hostWr;
  logic [ADDR_W-1:0] hostAddr, memAddr, snpAddr;
  logic hostRdy, sramCs, sramOe, sramWe, sramAdv, sramStandby;
  logic memReq, memWr, snpReq, snpWr, snpAck, snpWbReq;
  logic memAck = 1'b0;

  secCacheTop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .cacheEn(cacheEn), .bigSize(bigSize),
    .burstSram(burstSram), .hostReq(hostReq), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostRdy(hostRdy), .sramCs(sramCs), .sramOe(sramOe),
    .sramWe(sramWe), .sramAdv(sramAdv), .sramStandby(sramStandby),
    .memReq(memReq), .memWr(memWr), .memAddr(memAddr), .memAck(memAck),
    .snpReq(snpReq), .snpWr(snpWr), .snpAddr(snpAddr), .snpAck(snpAck),
    .snpWbReq(snpWbReq)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    string             req;
  } burst_t;
  burst_t expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic expectBurst(input logic wr, input logic [ADDR_W-1:0] a, input string req);
    burst_t b;
    b.wr = wr; b.addr = a & ~ADDR_W'(31); b.req = req;
    expQ.push_back(b);
  endtask

  // memory model and scoreboard monitor: ack on alternate cycles
  int beatCnt = 0;
  always @(negedge clk) begin
    if (memReq && !memAck) begin
      memAck <= 1'b1;
      beatCnt = beatCnt + 1;
      if (beatCnt == 4) begin
        beatCnt = 0;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 R8", "unexpected burst", {memWr, memAddr}, 0);
        end else begin
          burst_t e;
          e = expQ.pop_front();
          check(e.wr == memWr && e.addr == memAddr, e.req, "memory burst",
                {memWr, memAddr}, {e.wr, e.addr});
        end
      end
    end else begin
      memAck <= 1'b0;
    end
  end

  task automatic drained(input string req);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, req, "pending bursts", expQ.size(), 0);
  endtask

  // first: clock offset of first beat after the request edge, 0 = not timed
  task automatic access(input logic [ADDR_W-1:0] a, input bit wr,
                        input int first, input int gap, input string req);
    int n = 0;
    int t0;
    int offs[4];
    bit strobeOk = 1'b1;
    bit sbyOk = 1'b1;
    @(negedge clk);
    hostAddr = a; hostWr = wr; hostReq = 1'b1;
    t0 = cyc + 1;
    @(negedge clk);
    hostReq = 1'b0;
    for (int i = 0; i < 100 && n < 4; i++) begin
      @(negedge clk);
      #1;
      if (sramStandby) sbyOk = 1'b0;
      if (hostRdy) begin
        offs[n] = cyc - t0;
        if (first > 0) begin
          if (sramOe != !wr || sramWe != wr) strobeOk = 1'b0;
          if (gap == 1 && sramAdv != (n < 3)) strobeOk = 1'b0;
        end
        n++;
      end
    end
    check(n == 4, req, "beat count", n, 4);
    check(sbyOk, "R10", "standby during access", 0, 1);
    if (first > 0) begin
      for (int k = 0; k < 4; k++)
        check(offs[k] == first + k * gap, req, $sformatf("beat %0d offset", k),
              offs[k], first + k * gap);
      check(strobeOk, "R11", "hit SRAM strobes", 0, 1);
    end
  endtask

  task automatic snoop(input logic [ADDR_W-1:0] a, input bit wr,
                       input bit expWb, input string req);
    bit wbSeen = 1'b0;
    bit acked = 1'b0;
    @(negedge clk);
    snpAddr = a; snpWr = wr; snpReq = 1'b1;
    for (int i = 0; i < 100 && !acked; i++) begin
      @(negedge clk);
      #1;
      if (snpWbReq) wbSeen = 1'b1;
      if (snpAck) acked = 1'b1;
    end
    @(negedge clk);
    snpReq = 1'b0;
    check(acked, req, "snoop ack", acked, 1);
    check(wbSeen == expWb, req, "snoop writeback request", wbSeen, expWb);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  localparam logic [ADDR_W-1:0] A = 24'h001040;
  localparam logic [ADDR_W-1:0] C = A + CONF;
  localparam logic [ADDR_W-1:0] D = 24'h0022A0;
  localparam logic [ADDR_W-1:0] E = 24'h005500;

  initial begin
    rst = 1'b1; cacheEn = 1'b1; bigSize = 1'b0; burstSram = 1'b1;
    hostReq = 1'b0; hostWr = 1'b0; hostAddr = '0;
    snpReq = 1'b0; snpWr = 1'b0; snpAddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!hostRdy && !memReq && !snpAck && !snpWbReq, "R1", "idle outputs",
          {hostRdy, memReq, snpAck, snpWbReq}, 0);
    check(sramStandby, "R1", "standby after reset", sramStandby, 1);

    // R1 R4: cold read misses and fills
    expectBurst(0, A, "R4");
    access(A, 0, 0, 0, "R4");
    drained("R4");
    // R2: read hit 3-1-1-1
    access(A, 0, 2, 1, "R2");
    // R2 R5: write hit, no memory traffic
    access(A, 1, 2, 1, "R5");
    drained("R5");
    check(sramStandby, "R10", "standby when idle", sramStandby, 1);
    // R6 R7: conflicting line in small size evicts the dirty line
    expectBurst(1, A, "R6");
    expectBurst(0, C, "R6");
    access(C, 0, 0, 0, "R6");
    drained("R6");
    access(C, 0, 2, 1, "R6");
    // R5: write miss goes to memory without allocating
    expectBurst(1, D, "R5");
    access(D, 1, 0, 0, "R5");
    expectBurst(0, D, "R5");
    access(D, 0, 0, 0, "R5");
    drained("R5");

    // R3: standard SRAM timing
    burstSram = 1'b0;
    access(C, 0, 2, 2, "R3");
    access(C, 1, 3, 2, "R3");
    drained("R3");

    // R8: snoop read dirty hit flushes, line stays valid and clean
    expectBurst(1, C, "R8");
    snoop(C, 0, 1, "R8");
    drained("R8");
    access(C, 0, 2, 2, "R8");
    // R8: snoop write clean hit invalidates
    snoop(C, 1, 0, "R8");
    expectBurst(0, C, "R8");
    access(C, 0, 0, 0, "R8");
    // R8: snoop miss
    snoop(E, 1, 0, "R8");
    drained("R8");
    // R8: snoop write dirty hit flushes then invalidates
    access(C, 1, 3, 2, "R8");
    expectBurst(1, C, "R8");
    snoop(C, 1, 1, "R8");
    expectBurst(0, C, "R8");
    access(C, 0, 0, 0, "R8");
    drained("R8");

    // R7: large size keeps both lines resident
    burstSram = 1'b1; bigSize = 1'b1;
    doReset();
    expectBurst(0, A, "R7");
    access(A, 0, 0, 0, "R7");
    expectBurst(0, C, "R7");
    access(C, 0, 0, 0, "R7");
    access(A, 0, 2, 1, "R7");
    access(C, 0, 2, 1, "R7");
    drained("R7");

    // R9: caching disabled
    cacheEn = 1'b0; bigSize = 1'b0;
    doReset();
    expectBurst(0, A, "R9");
    access(A, 0, 0, 0, "R9");
    expectBurst(0, A, "R9");
    access(A, 0, 0, 0, "R9");
    expectBurst(1, A, "R9");
    access(A, 1, 0, 0, "R9");
    drained("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule